// File: doc/BRIEF.md
# Four-Channel DMA Control, Mask and Status Unit

This block holds the controller-wide registers of a four-channel DMA engine: the command byte, the per-channel mode bytes, the four-bit channel mask and the eight-bit status byte. The status byte carries one terminal-count flag per channel in bits [3:0] and one pending-request flag per channel in bits [7:4]. Software reaches these registers through a byte-wide control port. Peripherals reach the request flags directly through hold and release lines. The transfer engine reports each finished block through a terminal-count pulse.

From the registered mask and request flags, the unit picks one channel to service and drives a one-hot grant. Channel 0 has the highest priority. The unit also emits a one-cycle pulse that tells the address/count datapath to clear its byte pointer. Counting and address generation live outside this block.

Top module: `dma_ctl_unit`

## Requirements
- R1: The register index is `(ofs >> SHIFT) & 0xF`. Writes to indices 8 to 15 change no state. Reads of any index other than 0 and 1 return 0x00, and `rdata` is 0x00 whenever `rd_en` is low.
- R2: A write to index 0 stores the data byte as the command only if the byte is 0x00 or 0x04. Any other byte leaves the command unchanged, and `cmd_reject` is then high for exactly the following cycle. The stored byte is visible on `cmd_byte`.
- R3: A write to index 1 selects channel `c = wdata[1:0]`. It sets status bit `c+4` to `wdata[2]` and always clears status bit `c`.
- R4: A write to index 2 sets mask bit `wdata[1:0]` when `wdata[2]` is 1, and clears that bit when `wdata[2]` is 0.
- R5: A write to index 3 stores the whole data byte as the mode of channel `wdata[1:0]`. It appears on `mode_cfg[8*c +: 8]` from the next cycle. Modes are 0 after `rst_n`.
- R6: A write to index 4 raises `ptr_clr` for exactly the next cycle and changes no other state.
- R7: A write to index 5 sets the mask to 0xF, clears the status and command bytes, and raises `ptr_clr` for the next cycle. Modes are left unchanged. After `rst_n` the mask is also 0xF and the status and command bytes are 0.
- R8: A write to index 6 clears all four mask bits. A write to index 7 loads the mask from `wdata[3:0]`.
- R9: A read of index 0 returns the status byte in the same cycle, then clears status bits [3:0] at the clock edge. A terminal-count pulse in that same cycle still sets its bit. A read of index 1 returns `{4'b0000, mask}`.
- R10: `req_hold[c]` sets status bit `c+4` and `req_release[c]` clears it. If both arrive together, the release wins.
- R11: `tc_pulse[c]` sets status bit `c` and clears status bit `c+4`.
- R12: `grant` is one-hot on the lowest-numbered channel whose mask bit is 0 and whose request bit is 1. It is zero when no channel qualifies, and it follows the registered state from the cycle after a change.
- R13: In one cycle, a request write to channel `c` overrides hold, release and terminal-count on that channel. A master reset overrides every other event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ofs | input | OFS_W | Control port byte offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| req_hold | input | 4 | Per-channel external request set |
| req_release | input | 4 | Per-channel external request clear |
| tc_pulse | input | 4 | Per-channel terminal-count pulse |
| mode_cfg | output | 32 | Four mode bytes, channel 0 in bits [7:0] |
| cmd_byte | output | 8 | Stored command byte |
| ptr_clr | output | 1 | One-cycle byte-pointer clear pulse |
| cmd_reject | output | 1 | One-cycle flag after a rejected command |
| grant | output | 4 | One-hot service channel |

## Verification
The assertions assume three things about the inputs:
- A read and a write never share a cycle.
- `wdata` is stable while a strobe is high.
- Each per-channel line carries at most one event per cycle; a hold and a release together are allowed and resolved by R10.

The stimulus drives at most one strobe per cycle and draws hold, release and terminal-count bits sparsely. It also forces the collisions that R9, R10 and R13 define: a read with a terminal-count, a hold with a release, and a hold with a request write.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int CH_NUM = 4;
  localparam int CH_W   = 2;
  localparam int BYTE_W = 8;

  // write strobes, one per register index 0..7
  typedef struct packed {
    logic wmask;
    logic unmask;
    logic mrst;
    logic ptrclr;
    logic mode;
    logic smask;
    logic req;
    logic cmd;
  } wr_stb_t;

  function automatic logic [3:0] reg_index(input logic [15:0] ofs, input int unsigned sh);
    logic [15:0] s;
    s = ofs >> sh;
    return s[3:0];
  endfunction

  // only zero or the lone supported control bit may be stored
  function automatic logic cmd_allowed(input logic [BYTE_W-1:0] d);
    return (d & 8'hFB) == 8'h00;
  endfunction

  function automatic logic [CH_NUM-1:0] lowest_set(input logic [CH_NUM-1:0] v);
    return v & (~v + 1'b1);
  endfunction
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int SHIFT = 0
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic             wr_en,
  input  logic             rd_en,
  output wr_stb_t          stb,
  output logic             rd_status,
  output logic             rd_mask
);
  logic [3:0] idx;
  assign idx = reg_index(16'(ofs), SHIFT);

  always_comb begin
    stb = '0;
    if (wr_en && !idx[3]) begin
      case (idx[2:0])
        3'd0: stb.cmd    = 1'b1;
        3'd1: stb.req    = 1'b1;
        3'd2: stb.smask  = 1'b1;
        3'd3: stb.mode   = 1'b1;
        3'd4: stb.ptrclr = 1'b1;
        3'd5: stb.mrst   = 1'b1;
        3'd6: stb.unmask = 1'b1;
        default: stb.wmask = 1'b1;
      endcase
    end
  end

  assign rd_status = rd_en && (idx == 4'd0);
  assign rd_mask   = rd_en && (idx == 4'd1);
endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_NUM-1:0] hold,
  input  logic [CH_NUM-1:0] rel,
  input  logic [CH_NUM-1:0] tc,
  input  logic              req_wr,
  input  logic [CH_W-1:0]   req_ch,
  input  logic              req_set,
  input  logic              rd_clr,
  input  logic              mrst,
  output logic [2*CH_NUM-1:0] status
);
  logic [CH_NUM-1:0] req_q, tcb_q, req_n, tcb_n;

  always_comb begin
    tcb_n = (rd_clr ? '0 : tcb_q) | tc;
    req_n = (req_q | hold) & ~rel & ~tc;
    if (req_wr) begin
      req_n[req_ch] = req_set;
      tcb_n[req_ch] = 1'b0;
    end
    if (mrst) begin
      req_n = '0;
      tcb_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      tcb_q <= '0;
    end else begin
      req_q <= req_n;
      tcb_q <= tcb_n;
    end
  end

  assign status = {req_q, tcb_q};
endmodule

// File: rtl/dma_ctl_mask.sv
module dma_ctl_mask
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smask_wr,
  input  logic              unmask_wr,
  input  logic              wmask_wr,
  input  logic              mrst,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CH_NUM-1:0] mask
);
  logic [CH_NUM-1:0] mask_n;

  always_comb begin
    mask_n = mask;
    if (smask_wr) mask_n[wdata[CH_W-1:0]] = wdata[2];
    if (unmask_wr) mask_n = '0;
    if (wmask_wr) mask_n = wdata[CH_NUM-1:0];
    if (mrst) mask_n = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '1;
    else        mask <= mask_n;
  end
endmodule

// File: rtl/dma_ctl_arbiter.sv
module dma_ctl_arbiter
  import dma_ctl_pkg::*;
(
  input  logic [CH_NUM-1:0] mask,
  input  logic [CH_NUM-1:0] req,
  output logic [CH_NUM-1:0] eligible,
  output logic [CH_NUM-1:0] grant
);
  assign eligible = ~mask & req;
  assign grant    = lowest_set(eligible);
endmodule

// File: rtl/dma_ctl_unit.sv
module dma_ctl_unit
  import dma_ctl_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int SHIFT = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [OFS_W-1:0]         ofs,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [BYTE_W-1:0]        rdata,
  input  logic [CH_NUM-1:0]        req_hold,
  input  logic [CH_NUM-1:0]        req_release,
  input  logic [CH_NUM-1:0]        tc_pulse,
  output logic [CH_NUM*BYTE_W-1:0] mode_cfg,
  output logic [BYTE_W-1:0]        cmd_byte,
  output logic                     ptr_clr,
  output logic                     cmd_reject,
  output logic [CH_NUM-1:0]        grant
);
  wr_stb_t             stb;
  logic                rd_status, rd_mask;
  logic                cmd_wr, req_wr, mode_wr, mrst_wr, ptrclr_wr;
  logic [2*CH_NUM-1:0] status_q;
  logic [CH_NUM-1:0]   mask_q;
  logic [CH_NUM-1:0]   eligible;

  dma_ctl_decode #(.OFS_W(OFS_W), .SHIFT(SHIFT)) u_dec (
    .ofs(ofs), .wr_en(wr_en), .rd_en(rd_en),
    .stb(stb), .rd_status(rd_status), .rd_mask(rd_mask)
  );

  assign cmd_wr    = stb.cmd;
  assign req_wr    = stb.req;
  assign mode_wr   = stb.mode;
  assign mrst_wr   = stb.mrst;
  assign ptrclr_wr = stb.ptrclr;

  dma_ctl_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .hold(req_hold), .rel(req_release), .tc(tc_pulse),
    .req_wr(req_wr), .req_ch(wdata[CH_W-1:0]), .req_set(wdata[2]),
    .rd_clr(rd_status), .mrst(mrst_wr), .status(status_q)
  );

  dma_ctl_mask u_mask (
    .clk(clk), .rst_n(rst_n),
    .smask_wr(stb.smask), .unmask_wr(stb.unmask), .wmask_wr(stb.wmask),
    .mrst(mrst_wr), .wdata(wdata), .mask(mask_q)
  );

  dma_ctl_arbiter u_arb (
    .mask(mask_q), .req(status_q[2*CH_NUM-1:CH_NUM]),
    .eligible(eligible), .grant(grant)
  );

  // per-channel mode bytes
  for (genvar c = 0; c < CH_NUM; c++) begin : g_mode
    logic [BYTE_W-1:0] mode_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else if (mode_wr && (wdata[CH_W-1:0] == CH_W'(c))) mode_q <= wdata;
    end
    assign mode_cfg[c*BYTE_W +: BYTE_W] = mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_byte   <= '0;
      cmd_reject <= 1'b0;
      ptr_clr    <= 1'b0;
    end else begin
      if (mrst_wr) cmd_byte <= '0;
      else if (cmd_wr && cmd_allowed(wdata)) cmd_byte <= wdata;
      cmd_reject <= cmd_wr && !cmd_allowed(wdata);
      ptr_clr    <= ptrclr_wr || mrst_wr;
    end
  end

  always_comb begin
    if (rd_status)    rdata = status_q;
    else if (rd_mask) rdata = {{(BYTE_W-CH_NUM){1'b0}}, mask_q};
    else              rdata = '0;
  end
endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk
  import dma_ctl_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [BYTE_W-1:0]   wdata,
  input logic [CH_NUM-1:0]   tc_pulse,
  input logic                cmd_wr,
  input logic                req_wr,
  input logic                mrst_wr,
  input logic                ptrclr_wr,
  input logic                rd_status,
  input logic [2*CH_NUM-1:0] status_q,
  input logic [CH_NUM-1:0]   mask_q,
  input logic [BYTE_W-1:0]   cmd_byte,
  input logic                cmd_reject,
  input logic                ptr_clr,
  input logic [CH_NUM-1:0]   grant
);
  a_r12_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r12_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (((grant & mask_q) == '0) && ((grant & status_q[2*CH_NUM-1:CH_NUM]) != '0)));

  a_r2_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_allowed(wdata)) |=> (cmd_reject && (cmd_byte == $past(cmd_byte))));

  a_r7_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_wr |=> ((mask_q == '1) && (status_q == '0) && (cmd_byte == '0) && ptr_clr));

  a_r6_ptr_source: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |-> $past(ptrclr_wr || mrst_wr));

  a_r9_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && (tc_pulse == '0) && !req_wr && !mrst_wr) |=> (status_q[CH_NUM-1:0] == '0));

  for (genvar c = 0; c < CH_NUM; c++) begin : g_tc
    a_r11_tc_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_pulse[c] && !mrst_wr && !(req_wr && (wdata[CH_W-1:0] == CH_W'(c))))
        |=> (status_q[c] && !status_q[c+CH_NUM]));
  end
endmodule

bind dma_ctl_unit dma_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wdata(wdata), .tc_pulse(tc_pulse),
  .cmd_wr(cmd_wr), .req_wr(req_wr), .mrst_wr(mrst_wr), .ptrclr_wr(ptrclr_wr),
  .rd_status(rd_status), .status_q(status_q), .mask_q(mask_q),
  .cmd_byte(cmd_byte), .cmd_reject(cmd_reject), .ptr_clr(ptr_clr), .grant(grant)
);

// File: tb/dma_ctl_unit_bench.sv
`timescale 1ns/1ps
module dma_ctl_unit_bench;
  localparam int OW = 8;
  localparam int SH = 1;
  localparam realtime HALF = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [OW-1:0] ofs = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  req_hold = '0, req_release = '0, tc_pulse = '0;
  logic [31:0] mode_cfg;
  logic [7:0]  cmd_byte;
  logic        ptr_clr, cmd_reject;
  logic [3:0]  grant;

  dma_ctl_unit #(.OFS_W(OW), .SHIFT(SH)) u_dma_ctl_unit (
    .clk(clk), .rst_n(rst_n), .ofs(ofs), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .req_hold(req_hold), .req_release(req_release),
    .tc_pulse(tc_pulse), .mode_cfg(mode_cfg), .cmd_byte(cmd_byte),
    .ptr_clr(ptr_clr), .cmd_reject(cmd_reject), .grant(grant)
  );

  always #(HALF) clk = ~clk;

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state
  logic [7:0] m_stat = 8'h00;
  logic [3:0] m_mask = 4'hF;
  logic [7:0] m_cmd = 8'h00;
  logic [7:0] m_mode [4] = '{default: 8'h00};
  logic       m_ptr = 1'b0, m_rej = 1'b0;

  function automatic logic [3:0] idx_of(input logic [OW-1:0] o);
    return 4'((o >> SH) % 16);
  endfunction

  function automatic logic [7:0] exp_read();
    if (!rd_en) return 8'h00;
    if (idx_of(ofs) == 4'd0) return m_stat;
    if (idx_of(ofs) == 4'd1) return {4'h0, m_mask};
    return 8'h00;
  endfunction

  function automatic logic [3:0] exp_grant();
    for (int c = 0; c < 4; c++)
      if (!m_mask[c] && m_stat[c+4]) return 4'(1 << c);
    return 4'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic advance_model();
    logic [3:0] ix;
    int ch;
    ix = idx_of(ofs);
    ch = int'(wdata[1:0]);
    for (int c = 0; c < 4; c++) begin
      logic r, t;
      r = m_stat[c+4];
      t = m_stat[c];
      if (rd_en && ix == 4'd0) t = 1'b0;
      if (tc_pulse[c]) begin t = 1'b1; r = 1'b0; end
      else begin
        if (req_hold[c]) r = 1'b1;
        if (req_release[c]) r = 1'b0;
      end
      if (wr_en && ix == 4'd1 && ch == c) begin r = wdata[2]; t = 1'b0; end
      m_stat[c+4] = r;
      m_stat[c] = t;
    end
    m_ptr = 1'b0;
    m_rej = 1'b0;
    if (wr_en) begin
      case (ix)
        4'd0: if (wdata == 8'h00 || wdata == 8'h04) m_cmd = wdata; else m_rej = 1'b1;
        4'd2: m_mask[ch] = wdata[2];
        4'd3: m_mode[ch] = wdata;
        4'd4: m_ptr = 1'b1;
        4'd5: begin m_ptr = 1'b1; m_mask = 4'hF; m_stat = 8'h00; m_cmd = 8'h00; end
        4'd6: m_mask = 4'h0;
        4'd7: m_mask = wdata[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " R12 grant"}, 32'(grant), 32'(exp_grant()));
    check({tag, " R2 cmd_byte"}, 32'(cmd_byte), 32'(m_cmd));
    check({tag, " R2 cmd_reject"}, 32'(cmd_reject), 32'(m_rej));
    check({tag, " R6 ptr_clr"}, 32'(ptr_clr), 32'(m_ptr));
    check({tag, " R5 mode"}, mode_cfg, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
  endtask

  // one cycle: drive at negedge, check read data, step model, check after edge
  task automatic cyc(input string tag, input logic w, input logic r, input logic [3:0] ix,
                     input logic [7:0] d, input logic [3:0] h, input logic [3:0] rl,
                     input logic [3:0] t);
    wr_en = w; rd_en = r;
    ofs = OW'({$urandom_range(0, 7), ix} << SH);
    wdata = d; req_hold = h; req_release = rl; tc_pulse = t;
    #1;
    check({tag, " R9 rdata"}, 32'(rdata), 32'(exp_read()));
    advance_model();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; req_hold = '0; req_release = '0; tc_pulse = '0;
    check_outputs(tag);
  endtask

  task automatic wr(input string tag, input logic [3:0] ix, input logic [7:0] d);
    cyc(tag, 1'b1, 1'b0, ix, d, 4'h0, 4'h0, 4'h0);
  endtask

  task automatic rd(input string tag, input logic [3:0] ix);
    cyc(tag, 1'b0, 1'b1, ix, 8'h00, 4'h0, 4'h0, 4'h0);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R7 reset");
    rd("R7 reset mask", 4'd1);
    rd("R7 reset status", 4'd0);
    // R2 command acceptance
    wr("R2 accept 04", 4'd0, 8'h04);
    wr("R2 reject 01", 4'd0, 8'h01);
    wr("R2 reject 84", 4'd0, 8'h84);
    wr("R2 accept 00", 4'd0, 8'h00);
    // R5 mode per channel
    wr("R5 mode ch2", 4'd3, 8'hAA);
    wr("R5 mode ch1", 4'd3, 8'h59);
    // R8 clear all masks, then R10 hold and R12 lowest grant
    wr("R8 unmask all", 4'd6, 8'h00);
    cyc("R10 hold 1,3", 1'b0, 1'b0, 4'd0, 8'h00, 4'b1010, 4'h0, 4'h0);
    cyc("R11 tc ch1", 1'b0, 1'b0, 4'd0, 8'h00, 4'h0, 4'h0, 4'b0010);
    rd("R9 read status", 4'd0);
    rd("R9 status after clear", 4'd0);
    // R9 read coinciding with a terminal count keeps the new flag
    cyc("R9 read with tc", 1'b0, 1'b1, 4'd0, 8'h00, 4'h0, 4'h0, 4'b0100);
    rd("R9 tc survived", 4'd0);
    // R3 request write
    wr("R3 request ch0", 4'd1, 8'h04);
    rd("R3 status", 4'd0);
    // R4 single mask
    wr("R4 mask ch0", 4'd2, 8'h04);
    rd("R4 mask read", 4'd1);
    wr("R4 unmask ch0", 4'd2, 8'h00);
    wr("R8 load mask", 4'd7, 8'hF8);
    rd("R8 mask read", 4'd1);
    // R10 simultaneous hold and release
    cyc("R10 hold+release", 1'b0, 1'b0, 4'd0, 8'h00, 4'b0100, 4'b0100, 4'h0);
    // R13 request write beats hold on the same channel
    cyc("R13 wr beats hold", 1'b1, 1'b0, 4'd1, 8'h02, 4'b0100, 4'h0, 4'b0100);
    rd("R13 status", 4'd0);
    // R1 out-of-range indices
    wr("R1 idx9 write", 4'd9, 8'hFF);
    wr("R1 idx15 write", 4'd15, 8'h00);
    rd("R1 idx12 read", 4'd12);
    rd("R1 idx3 read", 4'd3);
    // R6 pointer clear alone
    wr("R6 ptr clear", 4'd4, 8'h55);
    // R7 master reset beats a simultaneous hold
    cyc("R7 master reset", 1'b1, 1'b0, 4'd5, 8'h00, 4'b0001, 4'h0, 4'h0);
    rd("R7 mask after", 4'd1);

    for (int n = 0; n < 4000; n++) begin
      logic w, r;
      logic [7:0] d;
      int op;
      op = $urandom_range(0, 9);
      w = (op < 5);
      r = (op >= 5 && op < 8);
      d = 8'($urandom());
      if ($urandom_range(0, 1) == 1) d = ($urandom_range(0, 1) == 1) ? 8'h04 : 8'h00;
      cyc("rand", w, r, 4'($urandom_range(0, 15)), d,
          4'($urandom() & $urandom() & $urandom()),
          4'($urandom() & $urandom() & $urandom()),
          4'($urandom() & $urandom() & $urandom() & $urandom()));
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(2 * HALF * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R12 watchdog: actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule